// File: doc/BRIEF.md
# Serial 010 Recogniser with Permanent Lockout

This block watches a serial stream of single bits and raises its match output whenever the three most recently accepted bits read 0, 1, 0, oldest first. Matches may overlap, so a stream such as 0 1 0 1 0 produces two matches. Only bits presented while the valid qualifier is high are accepted; other cycles leave the block untouched.

A second pattern, 1 0 0, acts as a kill sequence. The first time it appears among the accepted bits since reset, the block falls into an absorbing lockout state: the match output stays low for every later bit and a status output reports the lockout. Only reset leaves that state, and reset also discards any partially matched history. Both outputs are registered Moore outputs and change only on the clock edge that accepts a bit.

Top module: `seq_lock_detector`

## Requirements
- R1: `z` is 1 in the cycle after the edge that accepts a bit, exactly when the last three accepted bits are 0, 1, 0 (oldest first) and no lockout is in force; otherwise `z` is 0.
- R2: Matches overlap: the accepted stream 0,1,0,1,0 gives `z` = 0,0,1,0,1 after each bit.
- R3: Once the accepted bits have contained 1,0,0 since reset, `locked` is 1 and `z` is 0 for every following cycle until reset.
- R4: A rising edge with `in_valid` low accepts no bit: `z` and `locked` keep their values and the match history continues as if the cycle had not occurred.
- R5: While `rst_n` is low, `z` and `locked` are 0; after reset the lockout and any partial match are gone.
- R6: The accepted stream 0,0,1,0,1,0,1,0,0,1,0 gives `z` = 0,0,0,1,0,1,0,1,0,0,0.
- R7: The accepted stream 1,1,0,1,1,0,1,0,0,1,0 gives `z` = 0,0,0,0,0,0,0,1,0,0,0.
- R8: Runs of repeated 0s keep the block waiting for a 1 (so 0,0,0,1,0 matches on the last bit), and runs of repeated 1s keep it waiting for a 0 (so 1,1,1,0,0 locks on the last bit).
- R9: `locked` is 0 whenever no 1,0,0 has been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `x` for acceptance on this edge |
| x | input | 1 | Serial data bit |
| z | output | 1 | Registered match flag for 0,1,0 |
| locked | output | 1 | Registered flag, high in the lockout state |

## Verification
On every cycle the assertions check that the lockout is absorbing, that `z` and `locked` are never high together, that idle cycles leave both outputs unchanged, and that `z` or `locked` can only rise on an edge that accepted a 0. Whether `z` rises on the correct bit positions, that overlapping matches are counted, that the history clears on reset and that runs of equal bits are handled can only be shown by the bench, which compares the outputs against a model built from the last three accepted bits over directed streams and long random ones with gaps and resets.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  // Each state names the relevant suffix of the accepted stream.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // nothing accepted yet
    ST_Z     = 3'd1,  // ends in 0, not preceded by 1
    ST_ZO    = 3'd2,  // ends in 0,1
    ST_O     = 3'd3,  // ends in 1, not preceded by 0
    ST_OZ    = 3'd4,  // ends in 1,0 (no match)
    ST_HIT   = 3'd5,  // ends in 0,1,0 : match
    ST_DEAD  = 3'd6   // 1,0,0 seen : absorbing lockout
  } rec_state_e;

  localparam int unsigned STATE_W = $bits(rec_state_e);

endpackage

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_pkg::*;
(
  input  rec_state_e cur_state,
  input  logic       bit_in,
  output rec_state_e nxt_state
);

  always_comb begin
    nxt_state = cur_state;
    unique case (cur_state)
      ST_IDLE: nxt_state = bit_in ? ST_O  : ST_Z;
      ST_Z:    nxt_state = bit_in ? ST_ZO : ST_Z;
      ST_ZO:   nxt_state = bit_in ? ST_O  : ST_HIT;
      ST_O:    nxt_state = bit_in ? ST_O  : ST_OZ;
      ST_OZ:   nxt_state = bit_in ? ST_ZO : ST_DEAD;
      ST_HIT:  nxt_state = bit_in ? ST_ZO : ST_DEAD;
      ST_DEAD: nxt_state = ST_DEAD;
      default: nxt_state = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seq_lock_state.sv
module seq_lock_state
  import seq_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_en,
  input  rec_state_e nxt_state,
  output rec_state_e cur_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state <= ST_IDLE;
    end else if (step_en) begin
      cur_state <= nxt_state;
    end
  end

  // R3: lockout state is never left without reset
  assert_dead_absorbs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_DEAD) |=> (cur_state == ST_DEAD));

  // R4: no step, no state change
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cur_state));

endmodule

// File: rtl/seq_lock_out.sv
module seq_lock_out
  import seq_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_en,
  input  rec_state_e nxt_state,
  output logic       match_q,
  output logic       dead_q
);

  logic match_d;
  logic dead_d;

  always_comb begin
    match_d = (nxt_state == ST_HIT);
    dead_d  = (nxt_state == ST_DEAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      dead_q  <= 1'b0;
    end else if (step_en) begin
      match_q <= match_d;
      dead_q  <= dead_d;
    end
  end

  // R3: a lockout never shows a match
  assert_no_match_when_dead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> !match_q);

endmodule

// File: rtl/seq_lock_detector.sv
module seq_lock_detector
  import seq_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic x,
  output logic z,
  output logic locked
);

  rec_state_e cur_state;
  rec_state_e nxt_state;

  seq_lock_next u_next (
    .cur_state (cur_state),
    .bit_in    (x),
    .nxt_state (nxt_state)
  );

  seq_lock_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (in_valid),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  seq_lock_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (in_valid),
    .nxt_state (nxt_state),
    .match_q   (z),
    .dead_q    (locked)
  );

  // R3: lockout is absorbing at the ports
  assert_locked_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R4: cycles without in_valid leave outputs untouched
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(z) && $stable(locked)));

  // R1: a match only appears right after an accepted 0
  assert_match_after_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z) |-> ($past(in_valid) && !$past(x)));

  // R9: lockout only begins right after an accepted 0
  assert_lock_after_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(in_valid) && !$past(x)));

  // R3: the two outputs are exclusive
  assert_outputs_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({z, locked}));

endmodule

// File: tb/seq_lock_detector_bench.sv
module seq_lock_detector_bench;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic x;
  logic z;
  logic locked;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;

  // reference model state
  logic [2:0]  hist;
  int unsigned nacc;
  bit          m_lock;

  seq_lock_detector u_seq_lock_detector (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .x        (x),
    .z        (z),
    .locked   (locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic bit exp_z();
    return !m_lock && (nacc >= 3) && (hist == 3'b010);
  endfunction

  function automatic void model_accept(input logic b);
    hist = {hist[1:0], b};
    nacc = nacc + 1;
    if (nacc >= 3 && hist == 3'b100) m_lock = 1'b1;
  endfunction

  function automatic void model_reset();
    hist   = 3'b000;
    nacc   = 0;
    m_lock = 1'b0;
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (z !== exp_z() || locked !== m_lock) begin
      n_bad++;
      $display("FAIL %s: z=%0b locked=%0b expected z=%0b locked=%0b",
               tag, z, locked, exp_z(), m_lock);
    end
  endtask

  task automatic step(input logic b, input logic v, input string tag);
    x = b;
    in_valid = v;
    @(posedge clk);
    #1;
    if (v) model_accept(b);
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    @(posedge clk);
    #1;
    check(tag);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [10:0] bits, input logic [10:0] zexp,
                         input string tag);
    do_reset(tag);
    for (int i = 10; i >= 0; i--) begin
      step(bits[i], 1'b1, tag);
      n_chk++;
      if (z !== zexp[i]) begin
        n_bad++;
        $display("FAIL %s: bit %0d z=%0b expected %0b", tag, 10 - i, z, zexp[i]);
      end
    end
  endtask

  initial begin
    done = 1'b0;
    n_chk = 0;
    n_bad = 0;
    x = 1'b0;
    in_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    #3;
    check("R5 reset state");
    do_reset("R5 reset state");

    run_vec(11'b00101010010, 11'b00010101000, "R6");
    run_vec(11'b11011010010, 11'b00000001000, "R7");

    // R2 overlap
    do_reset("R2");
    step(0, 1, "R2"); step(1, 1, "R2"); step(0, 1, "R2");
    step(1, 1, "R2"); step(0, 1, "R2");

    // R4: gaps inside a match and after it
    do_reset("R4");
    step(0, 1, "R4"); step(1, 0, "R4 gap"); step(0, 0, "R4 gap");
    step(1, 1, "R4"); step(0, 0, "R4 gap"); step(0, 1, "R4 match after gap");
    step(0, 0, "R4 gap hold match");

    // R8 runs
    do_reset("R8");
    step(0, 1, "R8"); step(0, 1, "R8"); step(0, 1, "R8");
    step(1, 1, "R8"); step(0, 1, "R8 zeros then match");
    do_reset("R8");
    step(1, 1, "R8"); step(1, 1, "R8"); step(1, 1, "R8");
    step(0, 1, "R8"); step(0, 1, "R8 ones then lock");

    // R3 lockout persists
    for (int i = 0; i < 8; i++) step(i[0], 1'b1, "R3 locked stays");
    step(0, 1, "R3"); step(1, 1, "R3"); step(0, 1, "R3 no match when locked");

    // R5 reset clears partial history and lockout
    step(0, 1, "R5"); step(1, 1, "R5");
    do_reset("R5 clears lock");
    step(0, 1, "R5 history cleared");
    step(1, 1, "R5"); step(0, 1, "R1 match after reset");

    // R9 / R1 random
    void'($urandom(32'd2024));
    do_reset("R9");
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (m_lock && (r < 20)) begin
        do_reset("R5 random reset");
      end else begin
        step(logic'($urandom % 2), logic'(r < 80), "R1/R9 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule